// File: doc/BRIEF.md
# Bit-Addressable GPIO Port Controller

This block is the port unit of a small microcontroller. It owns nine bidirectional pins and two input-only pins, all selected by one 4-bit pin index. Bidirectional pins 0 to 8 each have an output data latch that a core sets or clears one bit at a time. Each of them also has a tri-state enable, held in memory-mapped buffer-control registers. A bit-test path returns the level of any pin, including the two input-only pins at indices 10 and 11.

The two input-only pins can also feed peripherals. When its select bit in a port mode register is set, pin 10 acts as a stop-request input and pin 11 acts as an external interrupt-0 input. A stop-clear input models the reset taken on entry to stop mode. It removes every buffer enable and every alternate-function selection, so all pins float, and it leaves the data latches as they are. A synchronous active-low reset clears the same state and also the data latches.

Top module: `gpio_bitport`

## Requirements
- R1: A `bit_set` strobe with `bit_idx` in 0..8 makes `pad_out[bit_idx]` 1 from the clock edge that samples the strobe.
- R2: A `bit_clr` strobe with `bit_idx` in 0..8 makes `pad_out[bit_idx]` 0 from the clock edge that samples the strobe.
- R3: When `bit_set` and `bit_clr` are both high for the same index, the latch is cleared to 0.
- R4: A set or clear strobe whose `bit_idx` is 9 to 15 changes no data latch.
- R5: A register write (`reg_we`) to buffer-control address 0x2C drives `pad_oe[3:0]`, 0x2D drives `pad_oe[7:4]` and bit 0 of 0x2E drives `pad_oe[8]`. Data bit k goes to the k-th pin of that group, the value applies from the edge that samples the write, and an enable of 0 means the pin is high-impedance.
- R6: `reg_rdata` is combinational. Buffer-control registers read back their enables, with the upper three bits of 0x2E reading 0. The mode register at 0x25 reads its selects in bits 2 and 3, with bits 1:0 reading 0. Any other address reads 0.
- R7: `test_bit` is combinational: `pad_in[i]` for index i in 0..8, `in_only[0]` for index 10, `in_only[1]` for index 11, and 0 for 9 and 12..15.
- R8: With mode bit 2 set, `stop_req` follows `in_only[0]`. With mode bit 3 set, `int0_req` follows `in_only[1]`. With the bit cleared, the request is 0. The test path keeps returning the raw pin level in both cases.
- R9: A `stop_clr` pulse clears all buffer enables and both mode selects at the next edge, overriding a write in the same cycle, and leaves the data latches unchanged.
- R10: `rst_n` low at a clock edge clears the data latches, the buffer enables and the mode selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_clr | input | 1 | Stop-mode clear pulse |
| bit_idx | input | 4 | Pin index for set, clear and test |
| bit_set | input | 1 | Set the addressed data latch |
| bit_clr | input | 1 | Clear the addressed data latch |
| test_bit | output | 1 | Level of the addressed pin |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data |
| pad_in | input | 9 | Sensed level of the bidirectional pins |
| in_only | input | 2 | Input-only pins 10 and 11 |
| pad_out | output | 9 | Data latch outputs |
| pad_oe | output | 9 | Output buffer enables |
| stop_req | output | 1 | Stop request from pin 10 |
| int0_req | output | 1 | Interrupt-0 request from pin 11 |

## Verification
Latch, enable and mode changes are due one clock edge after their strobe. The bench drives each strobe on a falling edge, drops it on the next falling edge and checks there, which is exactly one rising edge later. Register reads, `test_bit` and the two request outputs are combinational, so the bench samples them mid-cycle after changing their inputs, with no edge in between. Stop-clear and reset are checked the same way as latch updates: one edge after the pulse.

// File: rtl/gbp_pkg.sv
// Shared constants for the bit-addressable port controller.
// Assumes a 4-bit register data path and a 6-bit register address space.
package gbp_pkg;
    localparam int ADDR_W     = 6;
    localparam int GRP_W      = 4;
    localparam int IDX_W      = 4;
    localparam int N_IN       = 2;
    localparam int IN_BASE    = 10;
    localparam logic [ADDR_W-1:0] DCR_BASE  = 6'h2C;
    localparam logic [ADDR_W-1:0] MODE_ADDR = 6'h25;
    localparam int MODE_STOP_BIT = 2;
    localparam int MODE_INT_BIT  = 3;
endpackage

// File: rtl/gbp_data_latch.sv
// Output data latches for the bidirectional pins, updated by per-bit
// set and clear strobes. Assumes the strobes last one cycle. Clear wins
// over set. Indices at or above N_BIDIR are ignored.
module gbp_data_latch
    import gbp_pkg::*;
#(
    parameter int N_BIDIR = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   bit_idx,
    input  logic               bit_set,
    input  logic               bit_clr,
    output logic [N_BIDIR-1:0] q
);
    // Update the addressed latch bit; clear beats set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            for (int i = 0; i < N_BIDIR; i++) begin
                if (bit_idx == IDX_W'(i)) begin
                    if (bit_clr)      q[i] <= 1'b0;
                    else if (bit_set) q[i] <= 1'b1;
                end
            end
        end
    end

    // R3
    clr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_set && bit_clr && (int'(bit_idx) < N_BIDIR)) |=> !q[$past(bit_idx)]);

    // R4
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bit_set || bit_clr) && (int'(bit_idx) >= N_BIDIR)) |=> $stable(q));
endmodule

// File: rtl/gbp_ctrl_regs.sv
// Memory-mapped buffer-enable registers and port mode selects.
// Each enable register covers GRP_W pins, starting at DCR_BASE. Bits past
// the last pin are not stored and read as 0. The stop clear and the reset
// both clear all of them and take priority over a write.
module gbp_ctrl_regs
    import gbp_pkg::*;
#(
    parameter int N_BIDIR = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stop_clr,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [GRP_W-1:0]   reg_wdata,
    output logic [GRP_W-1:0]   reg_rdata,
    output logic [N_BIDIR-1:0] oe_q,
    output logic               sel_stop,
    output logic               sel_int0
);
    localparam int N_DCR = (N_BIDIR + GRP_W - 1) / GRP_W;

    // Write the enable bits of the addressed group and the mode selects
    always_ff @(posedge clk) begin
        if (!rst_n || stop_clr) begin
            oe_q     <= '0;
            sel_stop <= 1'b0;
            sel_int0 <= 1'b0;
        end else if (reg_we) begin
            for (int i = 0; i < N_BIDIR; i++) begin
                if (reg_addr == DCR_BASE + ADDR_W'(i / GRP_W))
                    oe_q[i] <= reg_wdata[i % GRP_W];
            end
            if (reg_addr == MODE_ADDR) begin
                sel_stop <= reg_wdata[MODE_STOP_BIT];
                sel_int0 <= reg_wdata[MODE_INT_BIT];
            end
        end
    end

    // Assemble the read data for the addressed register
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < N_DCR; k++) begin
            if (reg_addr == DCR_BASE + ADDR_W'(k)) begin
                for (int b = 0; b < GRP_W; b++) begin
                    if (k * GRP_W + b < N_BIDIR) reg_rdata[b] = oe_q[k * GRP_W + b];
                end
            end
        end
        if (reg_addr == MODE_ADDR) begin
            reg_rdata[MODE_STOP_BIT] = sel_stop;
            reg_rdata[MODE_INT_BIT]  = sel_int0;
        end
    end

    // R5
    dcr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !stop_clr && reg_addr == DCR_BASE) |=> oe_q[GRP_W-1:0] == $past(reg_wdata));

    // R9
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_clr |=> (oe_q == '0) && !sel_stop && !sel_int0);
endmodule

// File: rtl/gbp_pin_sense.sv
// Bit-test multiplexer and alternate-function routing for the
// input-only pins. Purely combinational. Assumes pin levels arrive
// already synchronised.
module gbp_pin_sense
    import gbp_pkg::*;
#(
    parameter int N_BIDIR = 9
) (
    input  logic [IDX_W-1:0]   bit_idx,
    input  logic [N_BIDIR-1:0] pad_in,
    input  logic [N_IN-1:0]    in_only,
    input  logic               sel_stop,
    input  logic               sel_int0,
    output logic               test_bit,
    output logic               stop_req,
    output logic               int0_req
);
    // Pick the raw level of the addressed pin
    always_comb begin
        test_bit = 1'b0;
        for (int i = 0; i < N_BIDIR; i++)
            if (bit_idx == IDX_W'(i)) test_bit = pad_in[i];
        for (int j = 0; j < N_IN; j++)
            if (bit_idx == IDX_W'(IN_BASE + j)) test_bit = in_only[j];
    end

    // Route the input-only pins to their peripherals when selected
    always_comb begin
        stop_req = sel_stop & in_only[0];
        int0_req = sel_int0 & in_only[1];
    end
endmodule

// File: rtl/gpio_bitport.sv
// Top of the bit-addressable port controller. Joins the data latches,
// the control registers and the pin sense logic. Assumes a synchronous
// active-low reset and single-cycle strobes.
module gpio_bitport
    import gbp_pkg::*;
#(
    parameter int N_BIDIR = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stop_clr,
    input  logic [IDX_W-1:0]   bit_idx,
    input  logic               bit_set,
    input  logic               bit_clr,
    output logic               test_bit,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [GRP_W-1:0]   reg_wdata,
    output logic [GRP_W-1:0]   reg_rdata,
    input  logic [N_BIDIR-1:0] pad_in,
    input  logic [N_IN-1:0]    in_only,
    output logic [N_BIDIR-1:0] pad_out,
    output logic [N_BIDIR-1:0] pad_oe,
    output logic               stop_req,
    output logic               int0_req
);
    logic sel_stop, sel_int0;

    gbp_data_latch #(.N_BIDIR(N_BIDIR)) latch_i (
        .clk(clk), .rst_n(rst_n), .bit_idx(bit_idx),
        .bit_set(bit_set), .bit_clr(bit_clr), .q(pad_out)
    );

    gbp_ctrl_regs #(.N_BIDIR(N_BIDIR)) regs_i (
        .clk(clk), .rst_n(rst_n), .stop_clr(stop_clr), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .oe_q(pad_oe), .sel_stop(sel_stop), .sel_int0(sel_int0)
    );

    gbp_pin_sense #(.N_BIDIR(N_BIDIR)) sense_i (
        .bit_idx(bit_idx), .pad_in(pad_in), .in_only(in_only),
        .sel_stop(sel_stop), .sel_int0(sel_int0), .test_bit(test_bit),
        .stop_req(stop_req), .int0_req(int0_req)
    );

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_clr |=> !stop_req && !int0_req && (pad_oe == '0));

    // R9
    stop_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_clr && !bit_set && !bit_clr) |=> $stable(pad_out));
endmodule

// File: tb/gpio_bitport_tb_top.sv
module gpio_bitport_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_clr = 1'b0;
    logic [3:0] bit_idx = '0;
    logic       bit_set = 1'b0, bit_clr = 1'b0, reg_we = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [3:0] reg_wdata = '0;
    logic [8:0] pad_in = '0;
    logic [1:0] in_only = '0;
    logic       test_bit, stop_req, int0_req;
    logic [3:0] reg_rdata;
    logic [8:0] pad_out, pad_oe;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    gpio_bitport dut_i (
        .clk(clk), .rst_n(rst_n), .stop_clr(stop_clr), .bit_idx(bit_idx),
        .bit_set(bit_set), .bit_clr(bit_clr), .test_bit(test_bit),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pad_in(pad_in), .in_only(in_only),
        .pad_out(pad_out), .pad_oe(pad_oe), .stop_req(stop_req), .int0_req(int0_req)
    );

    // op: 0 set, 1 clear, 2 both, 3 register write
    // {op[1:0], idx[3:0], addr[5:0], wdata[3:0], exp_out[8:0], exp_oe[8:0]}
    localparam int NV = 13;
    localparam logic [33:0] VEC [NV] = '{
        {2'd0, 4'd3,  6'h00, 4'h0, 9'h008, 9'h000},  // R1
        {2'd0, 4'd8,  6'h00, 4'h0, 9'h108, 9'h000},  // R1
        {2'd0, 4'd0,  6'h00, 4'h0, 9'h109, 9'h000},  // R1
        {2'd1, 4'd3,  6'h00, 4'h0, 9'h101, 9'h000},  // R2
        {2'd2, 4'd0,  6'h00, 4'h0, 9'h100, 9'h000},  // R3
        {2'd0, 4'd9,  6'h00, 4'h0, 9'h100, 9'h000},  // R4
        {2'd0, 4'd15, 6'h00, 4'h0, 9'h100, 9'h000},  // R4
        {2'd1, 4'd10, 6'h00, 4'h0, 9'h100, 9'h000},  // R4
        {2'd3, 4'd0,  6'h2C, 4'hA, 9'h100, 9'h00A},  // R5
        {2'd3, 4'd0,  6'h2D, 4'h5, 9'h100, 9'h05A},  // R5
        {2'd3, 4'd0,  6'h2E, 4'hF, 9'h100, 9'h15A},  // R5
        {2'd3, 4'd0,  6'h2E, 4'hE, 9'h100, 9'h05A},  // R5
        {2'd3, 4'd0,  6'h25, 4'hC, 9'h100, 9'h05A}   // R5
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Hold a strobe for one rising edge, releasing it at the next falling edge
    task automatic pulse(input logic [1:0] op, input logic [3:0] idx,
                         input logic [5:0] a, input logic [3:0] d);
        @(negedge clk);
        bit_idx = idx; reg_addr = a; reg_wdata = d;
        bit_set = (op == 2'd0 || op == 2'd2);
        bit_clr = (op == 2'd1 || op == 2'd2);
        reg_we  = (op == 2'd3);
        @(negedge clk);
        bit_set = 1'b0; bit_clr = 1'b0; reg_we = 1'b0;
    endtask

    initial begin
        #(20 * 5000);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: state after reset
        chk("R10", {7'd0, pad_out}, 16'h0);
        chk("R10", {7'd0, pad_oe}, 16'h0);

        for (int v = 0; v < NV; v++) begin
            pulse(VEC[v][33:32], VEC[v][31:28], VEC[v][27:22], VEC[v][21:18]);
            chk("R1-R5 vec out", {7'd0, pad_out}, {7'd0, VEC[v][17:9]});
            chk("R1-R5 vec oe",  {7'd0, pad_oe},  {7'd0, VEC[v][8:0]});
        end

        // R6: read back
        reg_addr = 6'h2C; #1 chk("R6", {12'd0, reg_rdata}, 16'hA);
        reg_addr = 6'h2D; #1 chk("R6", {12'd0, reg_rdata}, 16'h5);
        reg_addr = 6'h2E; #1 chk("R6", {12'd0, reg_rdata}, 16'h0);
        reg_addr = 6'h25; #1 chk("R6", {12'd0, reg_rdata}, 16'hC);
        reg_addr = 6'h2F; #1 chk("R6", {12'd0, reg_rdata}, 16'h0);

        // R7: bit test on bidirectional and input-only pins
        pad_in = 9'h0A5; in_only = 2'b01;
        bit_idx = 4'd0;  #1 chk("R7", {15'd0, test_bit}, 16'h1);
        bit_idx = 4'd1;  #1 chk("R7", {15'd0, test_bit}, 16'h0);
        bit_idx = 4'd7;  #1 chk("R7", {15'd0, test_bit}, 16'h1);
        bit_idx = 4'd12; #1 chk("R7", {15'd0, test_bit}, 16'h0);
        bit_idx = 4'd10; #1 chk("R7", {15'd0, test_bit}, 16'h1);
        bit_idx = 4'd11; #1 chk("R7", {15'd0, test_bit}, 16'h0);

        // R8: alternate functions active (mode = 0xC)
        #1 chk("R8 stop", {15'd0, stop_req}, 16'h1);
        chk("R8 int0", {15'd0, int0_req}, 16'h0);
        in_only = 2'b10; #1;
        chk("R8 stop", {15'd0, stop_req}, 16'h0);
        chk("R8 int0", {15'd0, int0_req}, 16'h1);
        bit_idx = 4'd11; #1 chk("R8 raw test", {15'd0, test_bit}, 16'h1);

        // R9: stop clear removes enables and modes but keeps data; beats a write
        @(negedge clk);
        stop_clr = 1'b1; reg_we = 1'b1; reg_addr = 6'h2C; reg_wdata = 4'hF;
        @(negedge clk);
        stop_clr = 1'b0; reg_we = 1'b0;
        chk("R9 oe", {7'd0, pad_oe}, 16'h0);
        chk("R9 data", {7'd0, pad_out}, 16'h100);
        chk("R9 int0", {15'd0, int0_req}, 16'h0);
        reg_addr = 6'h25; #1 chk("R9 mode", {12'd0, reg_rdata}, 16'h0);

        // R8: with mode cleared the requests stay low
        in_only = 2'b11; #1;
        chk("R8 off", {14'd0, stop_req, int0_req}, 16'h0);

        // R10: reset clears latches and enables
        pulse(2'd3, 4'd0, 6'h2D, 4'hF);
        chk("R5", {7'd0, pad_oe}, 16'h0F0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R10 data", {7'd0, pad_out}, 16'h0);
        chk("R10 oe", {7'd0, pad_oe}, 16'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule